// File: doc/BRIEF.md
# Daisy-Chained Serial Event Transmitter

This node turns parallel event words into frames on a single serial line and lets up to four chips share that line. A token, the grant, travels down the chain as a one-cycle pulse. A node that receives the grant while an event waits accepts the event and shifts its frame out one bit per clock. It then sends the grant pulse on to its downstream neighbour. A node that receives the grant with nothing to send forwards the pulse on the next cycle.

When a node is not transmitting, its serial output carries the serial data from its downstream neighbour. The frames of every chip further down the chain therefore pass through each upstream chip to the shared output. The request output is the OR of the local event valid and the request from downstream. An external chain master uses it to decide when to inject a grant at the head of the chain.

A frame holds 3 + PAYLOAD_W + 1 bits, in this order: a start bit of 1, the chip ID with its MSB first, the payload with its MSB first, and a stop bit of 0. The line idles low.

Top module: `chain_tx_node`

## Requirements
- R1: A frame is sent as follows: start bit 1, then the 2-bit chip ID with its MSB first, then the payload with its MSB first, then stop bit 0. The start bit appears in the cycle that follows the clock edge at which the event was accepted.
- R2: The frame bits go out one per clock, in FRAME_W consecutive cycles, with no gap.
- R3: evt_ready_o is high only while grant_i is high and the node is idle. An event that is presented without the grant is not sent.
- R4: If grant_i is high at an edge while the node is idle and evt_valid_i is low, grant_o is high for exactly the one cycle that follows that edge.
- R5: After a frame, grant_o is high for exactly one cycle, the cycle that follows the stop bit.
- R6: grant_o is never high while a frame is being transmitted.
- R7: While the node is not transmitting, ser_o equals ds_data_i combinationally.
- R8: While the node is transmitting, ds_data_i has no effect on ser_o.
- R9: After reset, the node is idle, grant_o is low, evt_ready_o is low while grant_i is low, and ser_o forwards ds_data_i.
- R10: req_o is high whenever evt_valid_i or req_i is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Readout clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chip_id_i | input | 2 | Position of this chip in the chain, inserted into each frame |
| evt_data_i | input | 16 | Event payload |
| evt_valid_i | input | 1 | Event word is valid |
| evt_ready_o | output | 1 | Event word is accepted at this edge |
| grant_i | input | 1 | Grant pulse from the upstream node |
| grant_o | output | 1 | Grant pulse to the downstream node |
| req_i | input | 1 | Request from the downstream node |
| req_o | output | 1 | Request toward upstream |
| ds_data_i | input | 1 | Serial data from the downstream node |
| ser_o | output | 1 | Serial output of this node |

## Verification
The event handshake is combinational, so ready is checked 1 ns after the inputs change, with no clock edge in between. The start bit is due in the cycle after the accepting edge, and frame bit b follows b cycles later. The grant pulse is due FRAME_W cycles after acceptance, or one cycle after an empty grant. The bench drives its inputs on the falling edge. It steps one rising edge per cycle and samples every registered output on the next falling edge. The result it checks is the one due after exactly the number of rising edges counted above. Forwarding and the request output are combinational and are sampled 1 ns after their inputs toggle.

// File: rtl/chain_tx_pkg.sv
package chain_tx_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } node_state_e;

  localparam int unsigned MAX_CHIPS = 4;
endpackage

// File: rtl/chain_tx_shifter.sv
module chain_tx_shifter #(
  parameter int unsigned ID_W      = 2,
  parameter int unsigned PAYLOAD_W = 16,
  parameter bit          STOP_BIT  = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [ID_W-1:0]      chip_id_i,
  input  logic [PAYLOAD_W-1:0] payload_i,
  output logic                 bit_o,
  output logic                 last_o
);
  localparam int unsigned FRAME_W = ID_W + PAYLOAD_W + 2;
  localparam int unsigned CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] frame_w;

  // start, id, payload, stop; MSB leaves first
  assign frame_w = {1'b1, chip_id_i, payload_i, STOP_BIT};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sr_q  <= frame_w;
      cnt_q <= CNT_TOP;
    end else if (cnt_q != '0) begin
      sr_q  <= {sr_q[FRAME_W-2:0], 1'b0};
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign bit_o  = sr_q[FRAME_W-1];
  assign last_o = (cnt_q == '0);

  assert_load_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == CNT_TOP));
  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/chain_tx_ctrl.sv
module chain_tx_ctrl
  import chain_tx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grant_i,
  input  logic evt_valid_i,
  input  logic last_i,
  output logic evt_ready_o,
  output logic load_o,
  output logic busy_o,
  output logic grant_o
);
  node_state_e state_q, state_d;
  logic        grant_q, grant_d;

  assign evt_ready_o = grant_i && (state_q == ST_IDLE);
  assign load_o      = evt_ready_o && evt_valid_i;
  assign busy_o      = (state_q == ST_SEND);
  assign grant_o     = grant_q;

  always_comb begin
    state_d = state_q;
    grant_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (grant_i) begin
          if (evt_valid_i) state_d = ST_SEND;
          else             grant_d = 1'b1;  // nothing to send: pass on
        end
      end
      ST_SEND: begin
        if (last_i) begin
          state_d = ST_IDLE;
          grant_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      grant_q <= 1'b0;
    end else begin
      state_q <= state_d;
      grant_q <= grant_d;
    end
  end

  assert_ready_needs_grant_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_ready_o |-> (grant_i && !busy_o));
  assert_empty_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i && !evt_valid_i && !busy_o) |=> grant_o);
  assert_grant_after_frame_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && last_i) |=> (grant_o && !busy_o));
  assert_no_grant_mid_frame_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !grant_o);
endmodule

// File: rtl/chain_tx_node.sv
module chain_tx_node #(
  parameter int unsigned NUM_CHIPS = 4,
  parameter int unsigned PAYLOAD_W = 16,
  localparam int unsigned ID_W     = $clog2(NUM_CHIPS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ID_W-1:0]      chip_id_i,
  input  logic [PAYLOAD_W-1:0] evt_data_i,
  input  logic                 evt_valid_i,
  output logic                 evt_ready_o,
  input  logic                 grant_i,
  output logic                 grant_o,
  input  logic                 req_i,
  output logic                 req_o,
  input  logic                 ds_data_i,
  output logic                 ser_o
);
  logic load_w, busy_w, last_w, bit_w;

  chain_tx_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .grant_i     (grant_i),
    .evt_valid_i (evt_valid_i),
    .last_i      (last_w),
    .evt_ready_o (evt_ready_o),
    .load_o      (load_w),
    .busy_o      (busy_w),
    .grant_o     (grant_o)
  );

  chain_tx_shifter #(
    .ID_W      (ID_W),
    .PAYLOAD_W (PAYLOAD_W),
    .STOP_BIT  (1'b0)
  ) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_w),
    .chip_id_i (chip_id_i),
    .payload_i (evt_data_i),
    .bit_o     (bit_w),
    .last_o    (last_w)
  );

  // own frame while busy, otherwise pass downstream data through
  assign ser_o = busy_w ? bit_w : ds_data_i;
  assign req_o = evt_valid_i || req_i;

  initial begin
    assert (NUM_CHIPS >= 2 && NUM_CHIPS <= chain_tx_pkg::MAX_CHIPS)
      else $error("NUM_CHIPS out of range");
  end

  assert_start_bit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_ready_o) |=> ser_o);
  assert_frame_unbroken_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_w && !last_w) |=> busy_w);
  assert_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i || req_i) |-> req_o);
endmodule

// File: tb/chain_tx_node_bench.sv
module chain_tx_node_bench;
  localparam int PW = 16;
  localparam int FW = PW + 4;
  localparam int NV = 8;

  // {valid, chip_id, payload}
  localparam logic [PW+2:0] VEC [NV] = '{
    {1'b1, 2'd0, 16'hA5C3},
    {1'b0, 2'd1, 16'h0000},
    {1'b1, 2'd3, 16'hFFFF},
    {1'b1, 2'd2, 16'h0000},
    {1'b0, 2'd2, 16'h1234},
    {1'b1, 2'd1, 16'h8001},
    {1'b1, 2'd3, 16'h5A5A},
    {1'b0, 2'd0, 16'hFFFF}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0] chip_id_i = '0;
  logic [PW-1:0] evt_data_i = '0;
  logic evt_valid_i = 1'b0, grant_i = 1'b0, req_i = 1'b0, ds_data_i = 1'b0;
  logic evt_ready_o, grant_o, req_o, ser_o;
  int checks = 0, fails = 0;

  always #2 clk_i = ~clk_i;

  chain_tx_node #(.NUM_CHIPS(4), .PAYLOAD_W(PW)) u_chain_tx_node (
    .clk_i, .rst_ni, .chip_id_i, .evt_data_i, .evt_valid_i, .evt_ready_o,
    .grant_i, .grant_o, .req_i, .req_o, .ds_data_i, .ser_o
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic round(input logic v, input logic [1:0] id, input logic [PW-1:0] pl);
    logic [FW-1:0] fr;
    fr = {1'b1, id, pl, 1'b0};
    chip_id_i = id; evt_data_i = pl; evt_valid_i = v; grant_i = 1'b1;
    #1 chk(evt_ready_o == 1'b1, "R3 ready with grant", evt_ready_o, 1);
    step();
    grant_i = 1'b0; evt_valid_i = 1'b0;
    if (v) begin
      for (int b = 0; b < FW; b++) begin
        chk(ser_o == fr[FW-1-b], (b == 0) ? "R1 start bit" : "R2 frame bit", ser_o, fr[FW-1-b]);
        chk(grant_o == 1'b0, "R6 grant mid frame", grant_o, 0);
        ds_data_i = ~ds_data_i;
        #1 chk(ser_o == fr[FW-1-b], "R8 ds ignored", ser_o, fr[FW-1-b]);
        step();
      end
      chk(grant_o == 1'b1, "R5 grant after frame", grant_o, 1);
      chk(ser_o == ds_data_i, "R7 forward after frame", ser_o, ds_data_i);
    end else begin
      chk(grant_o == 1'b1, "R4 empty pass", grant_o, 1);
    end
    step();
    chk(grant_o == 1'b0, v ? "R5 single pulse" : "R4 single pulse", grant_o, 0);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1;
    chk(grant_o == 1'b0, "R9 reset grant", grant_o, 0);
    chk(evt_ready_o == 1'b0, "R9 reset ready", evt_ready_o, 0);
    ds_data_i = 1'b1;
    #1 chk(ser_o == 1'b1, "R9 reset forward", ser_o, 1);
    ds_data_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    step();

    foreach (VEC[i]) round(VEC[i][PW+2], VEC[i][PW+1:PW], VEC[i][PW-1:0]);

    // R3: event without the grant is not taken
    evt_valid_i = 1'b1; evt_data_i = 16'hFFFF; chip_id_i = 2'd3;
    for (int c = 0; c < 4; c++) begin
      ds_data_i = c[0];
      #1 chk(evt_ready_o == 1'b0, "R3 no grant no ready", evt_ready_o, 0);
      chk(ser_o == c[0], "R3 no frame without grant", ser_o, c[0]);
      step();
      chk(grant_o == 1'b0, "R3 no grant out", grant_o, 0);
    end
    evt_valid_i = 1'b0; ds_data_i = 1'b0;

    // R7: idle forwarding follows ds_data_i
    for (int c = 0; c < 3; c++) begin
      ds_data_i = ~ds_data_i;
      #1 chk(ser_o == ds_data_i, "R7 idle forward", ser_o, ds_data_i);
    end
    ds_data_i = 1'b0;

    // R10: request combine
    for (int c = 0; c < 4; c++) begin
      evt_valid_i = c[0]; req_i = c[1];
      #1 chk(req_o == (c[0] | c[1]), "R10 request", req_o, c[0] | c[1]);
    end
    evt_valid_i = 1'b0; req_i = 1'b0;
    step();

    // back-to-back: grant returns and next event goes out at once
    round(1'b1, 2'd2, 16'h0F0F);
    round(1'b1, 2'd1, 16'hF0F0);

    // R9: reset mid-frame returns to idle forwarding
    chip_id_i = 2'd3; evt_data_i = 16'hFFFF; evt_valid_i = 1'b1; grant_i = 1'b1;
    step();
    grant_i = 1'b0; evt_valid_i = 1'b0;
    step();
    rst_ni = 1'b0;
    ds_data_i = 1'b0;
    #1 chk(ser_o == 1'b0, "R9 reset mid frame forward", ser_o, 0);
    chk(grant_o == 1'b0, "R9 reset mid frame grant", grant_o, 0);
    step();
    rst_ni = 1'b1;
    step();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule